// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

The sequencer takes the oscillator clock and turns it into a repeating train of four phase enables, Q1 to Q4. Each enable is high for one oscillator cycle, so four oscillator cycles make one instruction cycle. The sequencer uses these phases to run a two-stage pipeline that overlaps fetch with execute. A word is fetched from program memory and captured at the end of Q4. Over the next four phases that word is shown as the executing instruction, and the following word is fetched at the same time.

Program memory is read combinationally at the fetch address. The block samples the read data only in the last phase of each instruction cycle. The execute-stage outputs are the instruction register, the address tag of the word it holds, and a flag that marks the stage as empty in the first instruction cycle after reset. Decoding and executing the instruction belong to the logic downstream.

Top module: `qcycle_seq`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted and in the first oscillator cycle after release, `q_en` is 4'b0001 (Q1), `fetch_addr` is the reset address with bit 0 cleared, `ir` and `exec_addr` are zero, and `exec_nop` is 1.
- R2: In every oscillator cycle exactly one bit of `q_en` is set. Bit 0 is Q1 and bit 3 is Q4, and the set bit moves from Q1 to Q2, Q3, Q4 and back to Q1 on each clock.
- R3: `cyc_pulse` is high exactly in the oscillator cycles where Q1 is active, which is once every four cycles.
- R4: `fetch_addr` grows by 2 on the clock edge that ends Q4, so the new value is present from Q1 onward. It holds in all other phases.
- R5: Bit 0 of `fetch_addr` is always 0, and the address wraps modulo 2^AW.
- R6: `ir` loads the `imem_data` value that is present during Q4, on the edge that ends Q4. Values of `imem_data` in Q1 to Q3 have no effect, and `ir` holds through the next instruction cycle.
- R7: `exec_addr` is the fetch address from which `ir` was loaded. From the second instruction cycle after reset it equals `fetch_addr` minus 2.
- R8: `exec_nop` is 1 throughout the first instruction cycle after reset and 0 from the first Q4 capture until the next reset.
- R9: Asserting reset mid-cycle returns every output to its R1 state at once. After release the sequence restarts at Q1 with an empty execute stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_data | input | DW | Program-memory word read at `fetch_addr` |
| q_en | output | 4 | One-hot phase enables, bit 0 = Q1 to bit 3 = Q4 |
| cyc_pulse | output | 1 | Instruction-cycle strobe, high during Q1 |
| fetch_addr | output | AW | Byte address of the word being fetched |
| ir | output | DW | Instruction register (execute stage) |
| exec_addr | output | AW | Address tag of the word in `ir` |
| exec_nop | output | 1 | Execute stage holds no fetched word |

## Verification
The phase enables and the cycle strobe come from a single register, so each one changes on the clock edge after the previous phase. `fetch_addr`, `ir`, `exec_addr` and `exec_nop` change only on the edge that ends Q4. They are therefore due in the Q1 oscillator cycle that follows, and they hold for four cycles. The bench samples at the falling edge. From the count of oscillator cycles since reset release it derives the current phase and the instruction-cycle index k, and from those the expected fetch address 2k, the executing address 2(k-1) and the table word fetched there. The bench memory model drives a poison word outside Q4, so any capture in a phase other than Q4 shows up in `ir`.

// File: rtl/qcycle_seq.sv
module qcycle_seq #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] imem_data,
  output logic [3:0]    q_en,
  output logic          cyc_pulse,
  output logic [AW-1:0] fetch_addr,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] exec_addr,
  output logic          exec_nop
);
  localparam logic [AW-1:0] START = {RESET_ADDR[AW-1:1], 1'b0};
  localparam logic [AW-1:0] STEP  = AW'(2);

  logic [1:0] ph;
  logic       last;

  assign q_en      = 4'b0001 << ph;
  assign cyc_pulse = (ph == 2'd0);
  assign last      = (ph == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= 2'd0;
    else        ph <= ph + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fetch_addr <= START;
      ir         <= '0;
      exec_addr  <= '0;
      exec_nop   <= 1'b1;
    end else if (last) begin
      fetch_addr <= fetch_addr + STEP;
      ir         <= imem_data;
      exec_addr  <= fetch_addr;
      exec_nop   <= 1'b0;
    end
endmodule

// File: rtl/qcycle_seq_chk.sv
module qcycle_seq_chk #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] imem_data,
  input logic [3:0]    q_en,
  input logic          cyc_pulse,
  input logic [AW-1:0] fetch_addr,
  input logic [DW-1:0] ir,
  input logic [AW-1:0] exec_addr,
  input logic          exec_nop
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_en) == 1);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q_en == {$past(q_en[2:0]), $past(q_en[3])});

  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |=> !cyc_pulse);

  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_en[3] |=> fetch_addr == $past(fetch_addr) + AW'(2));

  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en[3] |=> $stable(fetch_addr));

  assert_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[0] == 1'b0);

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_en[3] |=> ir == $past(imem_data));

  assert_ir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en[3] |=> $stable(ir) && $stable(exec_addr));

  assert_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_en[3] |=> exec_addr == $past(fetch_addr));

  assert_nop_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_en[3] |=> !exec_nop);
endmodule

bind qcycle_seq qcycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/qcycle_seq_tb.sv
`timescale 1ns/1ps
module qcycle_seq_tb;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [DW-1:0] POISON = 16'hDEAD;
  localparam logic [DW-1:0] TBL [8] = '{16'h1234, 16'hA5A5, 16'h0F0F, 16'h8001,
                                        16'h7E7E, 16'h0000, 16'hFFFF, 16'h5A3C};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] imem_data;
  logic [3:0]    q_en;
  logic          cyc_pulse;
  logic [AW-1:0] fetch_addr;
  logic [DW-1:0] ir;
  logic [AW-1:0] exec_addr;
  logic          exec_nop;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign imem_data = q_en[3] ? TBL[fetch_addr[3:1]] : POISON;

  qcycle_seq #(.AW(AW), .DW(DW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_reset_state();
    chk("R1 q_en", 32'(q_en), 32'h1);
    chk("R1 fetch_addr", 32'(fetch_addr), 32'h0);
    chk("R1 ir", 32'(ir), 32'h0);
    chk("R1 exec_addr", 32'(exec_addr), 32'h0);
    chk("R1 exec_nop", 32'(exec_nop), 32'h1);
  endtask

  task automatic walk(input int n);
    for (int i = 0; i < n; i++) begin
      int ph = i % 4;
      int k  = i / 4;
      chk("R2 phase", 32'(q_en), 32'(1 << ph));
      chk("R3 strobe", 32'(cyc_pulse), 32'(ph == 0));
      chk("R4 fetch", 32'(fetch_addr), 32'(2 * k));
      chk("R5 even", 32'(fetch_addr[0]), 32'h0);
      chk("R8 nop", 32'(exec_nop), 32'(k == 0));
      if (k > 0) begin
        chk("R6 ir", 32'(ir), 32'(TBL[(k - 1) % 8]));
        chk("R7 tag", 32'(exec_addr), 32'(2 * (k - 1)));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    walk(48);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    chk("R9 strobe", 32'(cyc_pulse), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();
    walk(24);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule